// File: doc/BRIEF.md
# Wake Event Status and Power-Management Signal Controller

This block watches the byte stream of received Ethernet frames and decides whether a frame should wake a sleeping system. It checks each good frame against four wake sources. A destination equal to the 48-bit station address is one source. An all-ones broadcast destination is another. A magic packet carrying the station address is the third. A hit reported by an external pattern filter is the fourth. Each source has its own enable. A source that is enabled and fires sets a sticky flag. The enables and the flags share one control/status register.

Any set flag drives an active-low power-management event output (PME). That output can be routed to either of two pins. In the normal mode PME stays low until software clears the flags. In the self-clear mode PME is released by a timer after a programmed delay, and the flags stay as they are. The timer counts in units of a prescaled clock, so the reset delay value of 0x1000 works out to about 81 ms. Software reaches the control/status, station address and delay registers through a small register port that reads combinationally and writes on the clock edge.

Top module: `wake_pme_ctrl`

## Requirements
- R1: After reset, the control/status register (address 0) reads 0x0000, the delay register (address 4) reads 0x1000, and both PME pins are high.
- R2: The station address is held in three registers. Address 3 holds address bytes 0 and 1, address 2 holds bytes 2 and 3, and address 1 holds bytes 4 and 5. In each register the lower-numbered byte sits in bits 7:0 and the higher-numbered byte in bits 15:8. Address byte 0 is the first destination byte on the wire. All three registers read back what was written.
- R3: A good frame whose first six bytes equal the station address sets flag bit 7, provided enable bit 3 is set.
- R4: A good frame whose first six bytes are all 0xFF sets flag bit 4, provided enable bit 0 is set.
- R5: A good frame that contains six 0xFF bytes followed at once by 16 back-to-back copies of the station address, at any position, sets flag bit 5, provided enable bit 1 is set. A frame with only 15 copies sets no flag.
- R6: When the pattern-hit input is high on the end-of-frame byte of a good frame, flag bit 6 is set, provided enable bit 2 is set.
- R7: Flags change only on an end-of-frame byte with frame-good high. A frame ending with frame-good low, or a source whose enable is clear, sets no flag.
- R8: Flags are sticky. Writing 1 to a flag bit at address 0 clears that flag, and writing 0 leaves it unchanged. A set event in the same cycle as a clear wins.
- R9: With self-clear (bit 9) off, a routed PME pin is low exactly while any flag is set.
- R10: The value 2 in bits 14:13 routes PME to pin A, and the value 2 in bits 12:11 routes it to pin B. Any other value in a field keeps that pin high.
- R11: With self-clear on, a wake event drives the routed pin low for exactly delay × PRESCALE clock cycles. After that the pin goes high while the flags stay set. A delay of 0 counts as 1.
- R12: The delay register at address 4 reads back the value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_sof | input | 1 | This byte is the first byte of a frame |
| rx_eof | input | 1 | This byte is the last byte of a frame |
| rx_good | input | 1 | Frame passed its checks; sampled with rx_eof |
| rx_data | input | 8 | Received byte |
| wf_hit | input | 1 | Pattern filter hit, sampled with rx_eof |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| pme_a_n | output | 1 | Active-low PME, pin A |
| pme_b_n | output | 1 | Active-low PME, pin B |

## Verification
The bench builds the block with PRESCALE set to 4 and then programs a delay of 3. The self-clear window therefore lasts 12 cycles, which makes its exact first and last low cycles checkable within a short run. The 8-bit frame datapath and the six-byte address, 16-copy magic pattern keep their default sizes. The magic detector is therefore exercised at full length, including a frame one copy short. Both pin routings are covered, along with the rule that a set event beats a software clear.

// File: rtl/wake_pkg.sv
// Shared constants for the wake controller: register addresses, the
// routing code for the PME pins and the order of the wake sources.
// Assumes a 3-bit register address space.
package wake_pkg;
    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_STA45 = 3'd1;
    localparam logic [2:0] RA_STA23 = 3'd2;
    localparam logic [2:0] RA_STA01 = 3'd3;
    localparam logic [2:0] RA_DELAY = 3'd4;

    localparam logic [1:0] PIN_ROUTE = 2'd2;
    localparam logic [15:0] DELAY_RST = 16'h1000;

    // Source vector order, MSB first: unicast, pattern, magic, broadcast.
    // This matches enable bits 3:0 and flag bits 7:4.
    typedef struct packed {
        logic ucast;
        logic wframe;
        logic magic;
        logic bcast;
    } wake_src_t;
endpackage

// File: rtl/wake_dest_match.sv
// Destination address classifier. It compares the first AB bytes of each
// frame with the station address (byte k at station[8k+:8]) and with all
// ones. The hit outputs already include the current byte, so they are
// valid on the end-of-frame beat. Frames shorter than AB bytes never hit.
module wake_dest_match #(
    parameter int AB = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic          rx_sof,
    input  logic [7:0]    rx_data,
    input  logic [8*AB-1:0] station,
    output logic          uc_hit,
    output logic          bc_hit
);
    localparam int PW = $clog2(AB + 1);

    logic [PW-1:0] pos_q, pos_c, pos_n;
    logic          uc_q, bc_q, uc_n, bc_n;

    // next compare state, restarting on the first byte of a frame
    always_comb begin
        pos_c = rx_sof ? '0 : pos_q;
        uc_n  = rx_sof | uc_q;
        bc_n  = rx_sof | bc_q;
        pos_n = pos_c;
        if (pos_c < PW'(AB)) begin
            uc_n  = uc_n & (rx_data == station[8*pos_c +: 8]);
            bc_n  = bc_n & (rx_data == 8'hFF);
            pos_n = pos_c + PW'(1);
        end
        uc_hit = uc_n && (pos_n == PW'(AB));
        bc_hit = bc_n && (pos_n == PW'(AB));
    end

    // hold compare state between bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            uc_q  <= 1'b0;
            bc_q  <= 1'b0;
        end else if (rx_valid) begin
            pos_q <= pos_n;
            uc_q  <= uc_n;
            bc_q  <= bc_n;
        end
    end
endmodule

// File: rtl/wake_magic_det.sv
// Magic packet detector. It looks for SYNC_LEN bytes of 0xFF followed at
// once by COPIES back-to-back copies of the AB-byte station address,
// anywhere in the frame. The found output includes the current byte.
// Assumes station byte 0 is not 0xFF, which holds for unicast addresses.
module wake_magic_det #(
    parameter int AB       = 6,
    parameter int SYNC_LEN = 6,
    parameter int COPIES   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_valid,
    input  logic            rx_sof,
    input  logic [7:0]      rx_data,
    input  logic [8*AB-1:0] station,
    output logic            found
);
    localparam int FW = $clog2(SYNC_LEN + 1);
    localparam int CW = $clog2(COPIES + 1);
    localparam int BW = $clog2(AB + 1);

    logic [FW-1:0] ff_q, ff_c, ff_n;
    logic [CW-1:0] ci_q, ci_c, ci_n;
    logic [BW-1:0] bi_q, bi_c, bi_n;
    logic          m_q, m_c, m_n, f_q, f_n;
    logic          is_ff;

    // sync/copy tracking for the current byte
    always_comb begin
        ff_c  = rx_sof ? '0 : ff_q;
        ci_c  = rx_sof ? '0 : ci_q;
        bi_c  = rx_sof ? '0 : bi_q;
        m_c   = rx_sof ? 1'b0 : m_q;
        f_n   = rx_sof ? 1'b0 : f_q;
        is_ff = (rx_data == 8'hFF);
        ff_n  = ff_c;
        ci_n  = ci_c;
        bi_n  = bi_c;
        m_n   = m_c;
        if (m_c) begin
            if (rx_data == station[8*bi_c +: 8]) begin
                if (bi_c == BW'(AB - 1)) begin
                    bi_n = '0;
                    if (ci_c == CW'(COPIES - 1)) begin
                        f_n = 1'b1;
                        m_n = 1'b0;
                    end else begin
                        ci_n = ci_c + CW'(1);
                    end
                end else begin
                    bi_n = bi_c + BW'(1);
                end
            end else begin
                m_n  = 1'b0;
                ff_n = is_ff ? FW'(1) : '0;
            end
        end else if (is_ff) begin
            ff_n = (ff_c == FW'(SYNC_LEN)) ? ff_c : ff_c + FW'(1);
        end else if (ff_c == FW'(SYNC_LEN) && rx_data == station[7:0]) begin
            m_n  = 1'b1;
            bi_n = BW'(1);
            ci_n = '0;
            ff_n = '0;
        end else begin
            ff_n = '0;
        end
        found = f_n;
    end

    // hold detector state between bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ff_q <= '0;
            ci_q <= '0;
            bi_q <= '0;
            m_q  <= 1'b0;
            f_q  <= 1'b0;
        end else if (rx_valid) begin
            ff_q <= ff_n;
            ci_q <= ci_n;
            bi_q <= bi_n;
            m_q  <= m_n;
            f_q  <= f_n;
        end
    end
endmodule

// File: rtl/wake_pme_timer.sv
// Self-clear timer. A start pulse raises active and loads the delay; the
// count drops once every PRESCALE cycles, and active falls when it runs
// out, exactly delay*PRESCALE cycles after start. A new start restarts
// the window. A delay of 0 counts as 1.
module wake_pme_timer #(
    parameter int PRESCALE = 4944,
    parameter int DW       = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] delay,
    output logic          active
);
    localparam int PSW = $clog2(PRESCALE + 1);

    logic [PSW-1:0] pre_q;
    logic [DW-1:0]  cnt_q;
    logic           tick;

    assign tick = (pre_q == PSW'(PRESCALE - 1));

    // prescaler and delay countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            pre_q  <= '0;
            cnt_q  <= '0;
        end else if (start) begin
            active <= 1'b1;
            pre_q  <= '0;
            cnt_q  <= (delay == '0) ? DW'(1) : delay;
        end else if (active) begin
            if (tick) begin
                pre_q <= '0;
                if (cnt_q == DW'(1)) active <= 1'b0;
                else                 cnt_q  <= cnt_q - DW'(1);
            end else begin
                pre_q <= pre_q + PSW'(1);
            end
        end
    end
endmodule

// File: rtl/wake_pme_ctrl.sv
// Wake event controller top. It holds the control/status register (enables
// 3:0, sticky flags 7:4, self-clear 9, pin B route 12:11, pin A route
// 14:13), the station address and the self-clear delay. It sets flags on
// good end-of-frame beats and drives two active-low PME pins. Register
// reads are combinational and writes take effect at the clock edge.
module wake_pme_ctrl
    import wake_pkg::*;
#(
    parameter int PRESCALE = 4944
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic        rx_good,
    input  logic [7:0]  rx_data,
    input  logic        wf_hit,
    input  logic [2:0]  reg_addr,
    input  logic        reg_we,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        pme_a_n,
    output logic        pme_b_n
);
    localparam int AB = 6;

    wake_src_t     en_q, flag_q, hit, set_v;
    logic          sc_q;
    logic [1:0]    sel_a_q, sel_b_q;
    logic [15:0]   sta01_q, sta23_q, sta45_q, delay_q;
    logic [8*AB-1:0] station;
    logic          uc_hit, bc_hit, mp_found, eof_good, tmr_active, pme_on;
    logic          wr_ctrl;
    logic [3:0]    clr_v;

    assign station = {sta45_q, sta23_q, sta01_q};

    wake_dest_match #(.AB(AB)) u_dest (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_data(rx_data), .station(station), .uc_hit(uc_hit), .bc_hit(bc_hit)
    );

    wake_magic_det #(.AB(AB), .SYNC_LEN(6), .COPIES(16)) u_magic (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_data(rx_data), .station(station), .found(mp_found)
    );

    // per-source hits, gated by enables and qualified by a good frame end
    always_comb begin
        eof_good = rx_valid && rx_eof && rx_good;
        hit      = '{ucast: uc_hit, wframe: wf_hit, magic: mp_found, bcast: bc_hit};
        set_v    = eof_good ? (hit & en_q) : '0;
        wr_ctrl  = reg_we && (reg_addr == RA_CTRL);
        clr_v    = wr_ctrl ? reg_wdata[7:4] : 4'd0;
    end

    wake_pme_timer #(.PRESCALE(PRESCALE), .DW(16)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(|set_v), .delay(delay_q),
        .active(tmr_active)
    );

    // control/status and configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            flag_q  <= '0;
            sc_q    <= 1'b0;
            sel_a_q <= 2'd0;
            sel_b_q <= 2'd0;
            sta01_q <= '0;
            sta23_q <= '0;
            sta45_q <= '0;
            delay_q <= DELAY_RST;
        end else begin
            flag_q <= (flag_q & ~clr_v) | set_v;
            if (wr_ctrl) begin
                en_q    <= reg_wdata[3:0];
                sc_q    <= reg_wdata[9];
                sel_b_q <= reg_wdata[12:11];
                sel_a_q <= reg_wdata[14:13];
            end
            if (reg_we) begin
                case (reg_addr)
                    RA_STA01: sta01_q <= reg_wdata;
                    RA_STA23: sta23_q <= reg_wdata;
                    RA_STA45: sta45_q <= reg_wdata;
                    RA_DELAY: delay_q <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    // register read mux
    always_comb begin
        case (reg_addr)
            RA_CTRL:  reg_rdata = {1'b0, sel_a_q, sel_b_q, 1'b0, sc_q, 1'b0, flag_q, en_q};
            RA_STA01: reg_rdata = sta01_q;
            RA_STA23: reg_rdata = sta23_q;
            RA_STA45: reg_rdata = sta45_q;
            RA_DELAY: reg_rdata = delay_q;
            default:  reg_rdata = '0;
        endcase
    end

    // PME level and pin routing
    always_comb begin
        pme_on  = sc_q ? tmr_active : (|flag_q);
        pme_a_n = !(pme_on && (sel_a_q == PIN_ROUTE));
        pme_b_n = !(pme_on && (sel_b_q == PIN_ROUTE));
    end
endmodule

// File: rtl/wake_pme_ctrl_chk.sv
// Property checker for wake_pme_ctrl, attached by bind. It watches the
// stream strobes, register writes, the internal register fields and
// the PME pins.
module wake_pme_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_eof,
    input logic       rx_good,
    input logic       reg_we,
    input logic [2:0] reg_addr,
    input logic [3:0] en_v,
    input logic [3:0] flag_v,
    input logic       sc_v,
    input logic [1:0] sel_a_v,
    input logic [1:0] sel_b_v,
    input logic       pme_a_n,
    input logic       pme_b_n
);
    AST_BAD_FRAME_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_eof && rx_good) |=> ((flag_v & ~$past(flag_v)) == 4'd0)); // R7

    AST_FLAG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_v & ~$past(flag_v) & ~$past(en_v)) == 4'd0)); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(flag_v) & ~flag_v) != 4'd0) |-> $past(reg_we && reg_addr == 3'd0))); // R8

    AST_FLAG_DRIVES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!sc_v && (flag_v != 4'd0) && sel_a_v == 2'd2) |-> !pme_a_n); // R9

    AST_PIN_A_UNROUTED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a_v != 2'd2) |-> pme_a_n); // R10

    AST_PIN_B_UNROUTED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b_v != 2'd2) |-> pme_b_n); // R10
endmodule

bind wake_pme_ctrl wake_pme_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_eof(rx_eof),
    .rx_good(rx_good), .reg_we(reg_we), .reg_addr(reg_addr),
    .en_v(en_q), .flag_v(flag_q), .sc_v(sc_q), .sel_a_v(sel_a_q),
    .sel_b_v(sel_b_q), .pme_a_n(pme_a_n), .pme_b_n(pme_b_n)
);

// File: tb/test_wake_pme_ctrl.sv
// Directed bench for wake_pme_ctrl: one task per scenario.
module test_wake_pme_ctrl;
    localparam int PS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_good = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        wf_hit = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        pme_a_n, pme_b_n;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] fbuf [0:159];
    int flen;
    logic [7:0] sta [0:5];

    always #2 clk = ~clk;

    wake_pme_ctrl #(.PRESCALE(PS)) i_wake_pme_ctrl (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // the frame starts with the given 6-byte destination, then filler
    task automatic mk_frame(input logic [47:0] dst, input int len);
        for (int i = 0; i < 160; i++) fbuf[i] = 8'(i + 8'h30);
        for (int i = 0; i < 6; i++) fbuf[i] = dst[8*i +: 8];
        flen = len;
    endtask

    // send fbuf; ends at the negedge just after the end-of-frame edge
    task automatic send(input logic good, input logic hit);
        for (int i = 0; i < flen; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == flen - 1);
            rx_good = (i == flen - 1) ? good : 1'b0;
            wf_hit = (i == flen - 1) ? hit : 1'b0;
            rx_data = fbuf[i];
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0; wf_hit = 1'b0;
    endtask

    function automatic logic [47:0] sta_vec();
        return {sta[5], sta[4], sta[3], sta[2], sta[1], sta[0]};
    endfunction

    task automatic t_reset();
        logic [15:0] v;
        rd(3'd0, v); chk("R1 ctrl reset", v, 16'h0000);
        rd(3'd4, v); chk("R1 delay reset", v, 16'h1000);
        chk("R1 pins high", {14'd0, pme_a_n, pme_b_n}, 16'h0003);
        wr(3'd4, 16'h0003);
        rd(3'd4, v); chk("R12 delay readback", v, 16'h0003);
    endtask

    task automatic t_addr();
        logic [15:0] v;
        sta[0] = 8'h02; sta[1] = 8'h11; sta[2] = 8'h22;
        sta[3] = 8'h33; sta[4] = 8'h44; sta[5] = 8'h55;
        wr(3'd3, {sta[1], sta[0]});
        wr(3'd2, {sta[3], sta[2]});
        wr(3'd1, {sta[5], sta[4]});
        rd(3'd3, v); chk("R2 bytes0-1", v, 16'h1102);
        rd(3'd2, v); chk("R2 bytes2-3", v, 16'h3322);
        rd(3'd1, v); chk("R2 bytes4-5", v, 16'h5544);
    endtask

    task automatic t_ucast();
        logic [15:0] v;
        logic [47:0] bad;
        wr(3'd0, 16'h4008);
        bad = sta_vec() ^ 48'h0100_0000_0000;
        mk_frame(bad, 64); send(1'b1, 1'b0);
        rd(3'd0, v); chk("R3 mismatch byte5 no flag", v, 16'h4008);
        mk_frame(sta_vec(), 64); send(1'b1, 1'b0);
        rd(3'd0, v); chk("R3 unicast flag", v, 16'h4088);
        chk("R9 R10 pin A low, B high", {14'd0, pme_a_n, pme_b_n}, 16'h0001);
        wr(3'd0, 16'h4008);
        rd(3'd0, v); chk("R8 write 0 keeps flag", v, 16'h4088);
        wr(3'd0, 16'h4088);
        rd(3'd0, v); chk("R8 W1C clears", v, 16'h4008);
        chk("R9 pin A high after clear", {15'd0, pme_a_n}, 16'h0001);
    endtask

    task automatic t_bcast();
        logic [15:0] v;
        wr(3'd0, 16'h1001);
        mk_frame(48'hFFFF_FFFF_FFFF, 64); send(1'b0, 1'b0);
        rd(3'd0, v); chk("R7 bad frame no flag", v, 16'h1001);
        mk_frame(sta_vec(), 64); send(1'b1, 1'b1);
        rd(3'd0, v); chk("R7 disabled sources no flag", v, 16'h1001);
        mk_frame(48'hFFFF_FFFF_FFFF, 64); send(1'b1, 1'b0);
        rd(3'd0, v); chk("R4 broadcast flag", v, 16'h1011);
        chk("R10 pin B low, A high", {14'd0, pme_a_n, pme_b_n}, 16'h0002);
        // set event and W1C in the same cycle: the set wins
        for (int i = 0; i < flen; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == flen - 1);
            rx_good = (i == flen - 1); rx_data = fbuf[i];
            reg_addr = 3'd0; reg_wdata = 16'h1011; reg_we = (i == flen - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_eof = 1'b0; rx_good = 1'b0; reg_we = 1'b0;
        rd(3'd0, v); chk("R8 set beats clear", v, 16'h1011);
        wr(3'd0, 16'h1011);
    endtask

    task automatic t_magic();
        logic [15:0] v;
        int p;
        wr(3'd0, 16'h4002);
        for (int c = 15; c <= 16; c++) begin
            mk_frame(48'h0000_0000_AB00, 140);
            p = 20;
            for (int i = 0; i < 6; i++) fbuf[p + i] = 8'hFF;
            p += 6;
            for (int k = 0; k < c; k++)
                for (int i = 0; i < 6; i++) fbuf[p + 6*k + i] = sta[i];
            send(1'b1, 1'b0);
            rd(3'd0, v);
            if (c == 15) chk("R5 15 copies no flag", v, 16'h4002);
            else         chk("R5 magic flag", v, 16'h4022);
        end
        wr(3'd0, 16'h4022);
    endtask

    task automatic t_wframe();
        logic [15:0] v;
        wr(3'd0, 16'h4004);
        mk_frame(48'h0000_0000_AB00, 64); send(1'b1, 1'b1);
        rd(3'd0, v); chk("R6 pattern flag", v, 16'h4044);
        wr(3'd0, 16'h4044);
    endtask

    task automatic t_selfclr();
        logic [15:0] v;
        wr(3'd4, 16'h0003);
        wr(3'd0, 16'h4201);
        mk_frame(48'hFFFF_FFFF_FFFF, 64); send(1'b1, 1'b0);
        chk("R11 low after event", {15'd0, pme_a_n}, 16'h0000);
        repeat (3 * PS - 1) @(negedge clk);
        chk("R11 low at last cycle", {15'd0, pme_a_n}, 16'h0000);
        @(negedge clk);
        chk("R11 high after delay", {15'd0, pme_a_n}, 16'h0001);
        rd(3'd0, v); chk("R11 flag stays", v, 16'h4211);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_addr();
        t_ucast();
        t_bcast();
        t_magic();
        t_wframe();
        t_selfclr();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule